// File: doc/BRIEF.md
# Card Data Path Packing Engine

This block moves transfer data for a memory-card host controller. A word FIFO (16 entries of 32 bits by default) sits on the host side. A byte-wide card port with one valid/ready handshake per direction sits on the card side. Software first loads a 16-bit transfer length. It then writes the data-control register with the enable bit set, which copies the length into a byte down-counter and starts the engine. The engine moves at most one byte per clock.

When data flows from the card, incoming bytes are packed least-significant lane first into FIFO words. A word that is cut short by the end of the transfer is still pushed, with zeros in its upper lanes. When data flows to the card, each FIFO word is sent out lowest byte first. The engine reports FIFO level flags for the active direction only, sets two completion flags once the byte count runs out, and drops the enable bit by itself when nothing is left to move. A rounded-up word count is also available.

Card-to-FIFO refills pause after every host pop from the FIFO. They resume only after the host polls the status or the word count. This lets a slow reader drain the FIFO without new words arriving under it.

Top module: `card_fifo_engine`

## Requirements
- R1: A control write stores all 8 bits (bit 0 enable, bit 1 direction with 1 meaning card to host, bits 2 and 3 kept but without effect). A control write with bit 0 set loads the byte counter from the 16-bit length register. A control write with bit 0 clear leaves the counter unchanged.
- R2: The byte counter drops by exactly one for each byte that completes a card handshake, and at most one byte moves per clock.
- R3: In card-to-host mode, byte k of each group of four lands in word bits 8k+7..8k. When the counter reaches zero part-way through a word, that word is pushed with its unfilled upper bytes zero.
- R4: In host-to-card mode, each FIFO word is sent lowest byte first. Sending stops when the counter reaches zero, and the last word leaves the FIFO even if some of its bytes were not sent.
- R5: Status bits 8 and 10 both read 1 when the counter is zero after a control write with enable has occurred. Both read 0 out of reset.
- R6: While the engine is active, the transmit flags are reported in host-to-card mode and the receive flags in card-to-host mode. Transmit uses bit 12 active, 14 level at most half, 16 full, 18 empty, 20 nonempty. Receive uses 13 active, 15 level at least half, 17 full, 19 empty, 21 nonempty. The other group reads 0.
- R7: When the counter is zero and the FIFO is empty, the enable bit clears itself at the next clock, and all FIFO flags in status read 0.
- R8: After a host pop, no card byte is accepted until a status-poll or count-poll strobe arrives.
- R9: The word-count output equals (byte counter + 3) shifted right by 2.
- R10: A pop from an empty FIFO returns 0 and changes nothing. A host push while the counter is zero is ignored. A host push into a full FIFO is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len_we | input | 1 | Write strobe for the transfer length |
| cfg_len_wdata | input | 16 | Transfer length in bytes |
| ctrl_we | input | 1 | Write strobe for the data-control register |
| ctrl_wdata | input | 8 | Data-control write value |
| ctrl_rdata | output | 8 | Data-control register readback |
| stat_rd | input | 1 | Status poll strobe, releases the refill hold |
| cnt_rd | input | 1 | Word-count poll strobe, releases the refill hold |
| status | output | 22 | Completion and FIFO flags |
| byte_cnt | output | 16 | Bytes left in the transfer |
| word_cnt | output | 15 | Byte count rounded up to words |
| fifo_wr_en | input | 1 | Host push strobe |
| fifo_wr_data | input | 32 | Host push word |
| fifo_rd_en | input | 1 | Host pop strobe |
| fifo_rd_data | output | 32 | FIFO head word, 0 when empty |
| crd_rx_valid | input | 1 | Card offers a byte |
| crd_rx_data | input | 8 | Byte from the card |
| crd_rx_ready | output | 1 | Engine accepts a card byte |
| crd_tx_valid | output | 1 | Engine offers a byte to the card |
| crd_tx_data | output | 8 | Byte to the card |
| crd_tx_ready | input | 1 | Card accepts the byte |

## Verification
Control, length and FIFO effects appear one clock after their strobe. The status and word-count outputs are combinational on that registered state. The enable auto-clear lands one clock after the idle condition first holds, and a released refill moves its first byte one clock after the poll strobe. The bench drives strobes at the falling edge and samples at the next falling edge. For the exact one-byte-per-clock check it samples exactly one further cycle after a poll. Level and pattern checks wait a fixed margin that covers the longest transfer.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);
    localparam int CTRL_W = 8;
    localparam int STAT_W = 22;

    // Status bit positions decoded by software
    localparam int ST_DATA_END = 8;
    localparam int ST_BLK_END  = 10;
    localparam int ST_ACT      = 12;
    localparam int ST_HALF     = 14;
    localparam int ST_FULL     = 16;
    localparam int ST_EMPTY    = 18;
    localparam int ST_AVAIL    = 20;

    typedef struct packed {
        logic [3:0] spare;
        logic       dma;
        logic       mode;
        logic       dir;   // 1: card to host
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic active;
        logic half;
        logic full;
        logic empty;
        logic avail;
    } fifo_flags_t;

    // Place a flag group on the even (transmit) or odd (receive) bit lanes
    function automatic logic [STAT_W-1:0] place_group(input fifo_flags_t f, input logic rx);
        logic [STAT_W-1:0] s;
        int o;
        s = '0;
        o = rx ? 1 : 0;
        s[ST_ACT   + o] = f.active;
        s[ST_HALF  + o] = f.half;
        s[ST_FULL  + o] = f.full;
        s[ST_EMPTY + o] = f.empty;
        s[ST_AVAIL + o] = f.avail;
        return s;
    endfunction
endpackage

// File: rtl/cfe_word_fifo.sv
module cfe_word_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [LW-1:0]    level,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    assign head  = mem[rd_ptr];
    assign empty = (level == '0);
    assign full  = (level == LW'(DEPTH));
endmodule

// File: rtl/cfe_rx_pack.sv
module cfe_rx_pack
    import cfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              allow,
    input  logic              last_byte,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              take,
    output logic              push,
    output logic [WORD_W-1:0] word
);
    logic [LANE_W-1:0] lane;
    logic [WORD_W-1:0] acc;

    assign rx_ready = allow;
    assign take     = allow & rx_valid;
    assign word     = acc | (WORD_W'(rx_data) << (BYTE_W * lane));
    assign push     = take & ((lane == LANE_W'(LANES - 1)) | last_byte);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            lane <= '0;
            acc  <= '0;
        end else if (take) begin
            if (push) begin
                lane <= '0;
                acc  <= '0;
            end else begin
                lane <= lane + 1'b1;
                acc  <= word;
            end
        end
    end
endmodule

// File: rtl/cfe_tx_unpack.sv
module cfe_tx_unpack
    import cfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              allow,
    input  logic              last_byte,
    input  logic [WORD_W-1:0] head,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              take,
    output logic              pop
);
    logic [LANE_W-1:0] lane;

    assign tx_valid = allow;
    assign tx_data  = head[BYTE_W * lane +: BYTE_W];
    assign take     = allow & tx_ready;
    assign pop      = take & ((lane == LANE_W'(LANES - 1)) | last_byte);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            lane <= '0;
        end else if (take) begin
            lane <= pop ? '0 : lane + 1'b1;
        end
    end
endmodule

// File: rtl/cfe_status_gen.sv
module cfe_status_gen
    import cfe_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic              dir_rx,
    input  logic              active,
    input  logic              done,
    input  logic [LW-1:0]     level,
    output logic [STAT_W-1:0] status
);
    fifo_flags_t flags;

    always_comb begin
        flags.active = 1'b1;
        flags.empty  = (level == '0);
        flags.avail  = (level != '0);
        flags.full   = (level == LW'(DEPTH));
        flags.half   = dir_rx ? (level >= LW'(DEPTH / 2)) : (level <= LW'(DEPTH / 2));
        status = active ? place_group(flags, dir_rx) : '0;
        status[ST_DATA_END] = done;
        status[ST_BLK_END]  = done;
    end
endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine
    import cfe_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LEN_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_len_we,
    input  logic [LEN_W-1:0]   cfg_len_wdata,
    input  logic               ctrl_we,
    input  logic [CTRL_W-1:0]  ctrl_wdata,
    output logic [CTRL_W-1:0]  ctrl_rdata,
    input  logic               stat_rd,
    input  logic               cnt_rd,
    output logic [STAT_W-1:0]  status,
    output logic [LEN_W-1:0]   byte_cnt,
    output logic [LEN_W-2:0]   word_cnt,
    input  logic               fifo_wr_en,
    input  logic [WORD_W-1:0]  fifo_wr_data,
    input  logic               fifo_rd_en,
    output logic [WORD_W-1:0]  fifo_rd_data,
    input  logic               crd_rx_valid,
    input  logic [BYTE_W-1:0]  crd_rx_data,
    output logic               crd_rx_ready,
    output logic               crd_tx_valid,
    output logic [BYTE_W-1:0]  crd_tx_data,
    input  logic               crd_tx_ready
);
    localparam int LW = $clog2(DEPTH + 1);

    ctrl_t             ctrl_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              started_q;
    logic              hold_q;

    logic              cnt_zero, last_byte, restart, idle;
    logic              rx_allow, rx_take, rx_push;
    logic [WORD_W-1:0] rx_word;
    logic              tx_allow, tx_take, tx_pop;
    logic              host_push, host_pop;
    logic              push, pop;
    logic [WORD_W-1:0] push_data, head;
    logic [LW-1:0]     fifo_level;
    logic              fifo_empty, fifo_full;
    logic [LEN_W:0]    cnt_round;

    assign cnt_zero  = (cnt_q == '0);
    assign last_byte = (cnt_q == LEN_W'(1));
    assign restart   = ctrl_we & ctrl_wdata[0];
    assign idle      = cnt_zero & fifo_empty;

    assign rx_allow  = ctrl_q.en & ctrl_q.dir & ~cnt_zero & ~hold_q & ~fifo_full;
    assign tx_allow  = ctrl_q.en & ~ctrl_q.dir & ~cnt_zero & ~fifo_empty;

    // The packer owns the FIFO write port on the cycle it completes a word
    assign host_push = fifo_wr_en & ~cnt_zero & ~fifo_full & ~rx_push;
    assign push      = rx_push | host_push;
    assign push_data = rx_push ? rx_word : fifo_wr_data;
    assign host_pop  = fifo_rd_en & ~fifo_empty;
    assign pop       = host_pop | tx_pop;

    cfe_word_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W), .LW(LW)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head      (head),
        .level     (fifo_level),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    cfe_rx_pack u_rx (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .allow     (rx_allow),
        .last_byte (last_byte),
        .rx_valid  (crd_rx_valid),
        .rx_data   (crd_rx_data),
        .rx_ready  (crd_rx_ready),
        .take      (rx_take),
        .push      (rx_push),
        .word      (rx_word)
    );

    cfe_tx_unpack u_tx (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .allow     (tx_allow),
        .last_byte (last_byte),
        .head      (head),
        .tx_ready  (crd_tx_ready),
        .tx_valid  (crd_tx_valid),
        .tx_data   (crd_tx_data),
        .take      (tx_take),
        .pop       (tx_pop)
    );

    cfe_status_gen #(.DEPTH(DEPTH), .LW(LW)) u_stat (
        .dir_rx (ctrl_q.dir),
        .active (ctrl_q.en & ~idle),
        .done   (started_q & cnt_zero),
        .level  (fifo_level),
        .status (status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            len_q     <= '0;
            cnt_q     <= '0;
            started_q <= 1'b0;
            hold_q    <= 1'b0;
        end else begin
            if (cfg_len_we) len_q <= cfg_len_wdata;

            if (ctrl_we)                ctrl_q    <= ctrl_t'(ctrl_wdata);
            else if (ctrl_q.en && idle) ctrl_q.en <= 1'b0;

            if (restart)                cnt_q <= len_q;
            else if (rx_take || tx_take) cnt_q <= cnt_q - 1'b1;

            if (restart) started_q <= 1'b1;

            if (host_pop)              hold_q <= 1'b1;
            else if (stat_rd || cnt_rd) hold_q <= 1'b0;
        end
    end

    assign cnt_round    = {1'b0, cnt_q} + (LEN_W + 1)'(3);
    assign word_cnt     = cnt_round[LEN_W:2];
    assign byte_cnt     = cnt_q;
    assign ctrl_rdata   = ctrl_q;
    assign fifo_rd_data = fifo_empty ? '0 : head;
endmodule

// File: rtl/card_fifo_engine_chk.sv
module card_fifo_engine_chk #(
    parameter int DEPTH = 16,
    parameter int LEN_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ctrl_we,
    input logic [7:0]        ctrl_wdata,
    input logic [7:0]        ctrl_rdata,
    input logic              fifo_rd_en,
    input logic [21:0]       status,
    input logic [LEN_W-1:0]  byte_cnt,
    input logic              crd_rx_valid,
    input logic              crd_rx_ready,
    input logic              crd_tx_valid,
    input logic              crd_tx_ready,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic moved;
    assign moved = (crd_rx_valid & crd_rx_ready) | (crd_tx_valid & crd_tx_ready);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (moved && !(ctrl_we && ctrl_wdata[0])) |=> (byte_cnt == $past(byte_cnt) - ONE)); // R2

    AST_ONE_BYTE: assert property (@(posedge clk) disable iff (rst)
        !(crd_rx_ready && crd_tx_valid)); // R2

    AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (byte_cnt == '0) |-> (!crd_tx_valid && !crd_rx_ready)); // R4

    AST_DONE_PAIR: assert property (@(posedge clk) disable iff (rst)
        status[8] == status[10]); // R5

    AST_RX_GROUP_ONLY: assert property (@(posedge clk) disable iff (rst)
        ctrl_rdata[1] |-> (status[12] == 1'b0 && status[14] == 1'b0 && status[16] == 1'b0
                           && status[18] == 1'b0 && status[20] == 1'b0)); // R6

    AST_TX_GROUP_ONLY: assert property (@(posedge clk) disable iff (rst)
        !ctrl_rdata[1] |-> (status[13] == 1'b0 && status[15] == 1'b0 && status[17] == 1'b0
                            && status[19] == 1'b0 && status[21] == 1'b0)); // R6

    AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rdata[0] && byte_cnt == '0 && fifo_level == '0 && !ctrl_we) |=> !ctrl_rdata[0]); // R7

    AST_HOLD_AFTER_POP: assert property (@(posedge clk) disable iff (rst)
        (fifo_rd_en && fifo_level != '0) |=> !crd_rx_ready); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LW'(DEPTH)); // R10
endmodule

bind card_fifo_engine card_fifo_engine_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctrl_we      (ctrl_we),
    .ctrl_wdata   (ctrl_wdata),
    .ctrl_rdata   (ctrl_rdata),
    .fifo_rd_en   (fifo_rd_en),
    .status       (status),
    .byte_cnt     (byte_cnt),
    .crd_rx_valid (crd_rx_valid),
    .crd_rx_ready (crd_rx_ready),
    .crd_tx_valid (crd_tx_valid),
    .crd_tx_ready (crd_tx_ready),
    .fifo_level   (fifo_level)
);

// File: tb/card_fifo_engine_tb.sv
`timescale 1ns/1ps
module card_fifo_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_len_we = 1'b0;
    logic [15:0] cfg_len_wdata = '0;
    logic        ctrl_we = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [7:0]  ctrl_rdata;
    logic        stat_rd = 1'b0;
    logic        cnt_rd = 1'b0;
    logic [21:0] status;
    logic [15:0] byte_cnt;
    logic [14:0] word_cnt;
    logic        fifo_wr_en = 1'b0;
    logic [31:0] fifo_wr_data = '0;
    logic        fifo_rd_en = 1'b0;
    logic [31:0] fifo_rd_data;
    logic        crd_rx_valid;
    logic [7:0]  crd_rx_data;
    logic        crd_rx_ready;
    logic        crd_tx_valid;
    logic [7:0]  crd_tx_data;
    logic        crd_tx_ready = 1'b0;

    logic        card_on = 1'b0;
    logic        card_clr = 1'b0;
    logic [7:0]  seed = '0;
    logic [15:0] rx_idx;
    logic [7:0]  tx_bytes [64];
    logic [5:0]  tx_n;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    card_fifo_engine u_dut (
        .clk(clk), .rst(rst),
        .cfg_len_we(cfg_len_we), .cfg_len_wdata(cfg_len_wdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .stat_rd(stat_rd), .cnt_rd(cnt_rd),
        .status(status), .byte_cnt(byte_cnt), .word_cnt(word_cnt),
        .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
        .fifo_rd_en(fifo_rd_en), .fifo_rd_data(fifo_rd_data),
        .crd_rx_valid(crd_rx_valid), .crd_rx_data(crd_rx_data), .crd_rx_ready(crd_rx_ready),
        .crd_tx_valid(crd_tx_valid), .crd_tx_data(crd_tx_data), .crd_tx_ready(crd_tx_ready)
    );

    // Card model: counts source bytes, records sink bytes
    assign crd_rx_valid = card_on;
    assign crd_rx_data  = seed + rx_idx[7:0];

    always @(posedge clk) begin
        if (card_clr) begin
            rx_idx <= '0;
            tx_n   <= '0;
        end else begin
            if (crd_rx_valid && crd_rx_ready) rx_idx <= rx_idx + 1'b1;
            if (crd_tx_valid && crd_tx_ready) begin
                tx_bytes[tx_n] <= crd_tx_data;
                tx_n <= tx_n + 1'b1;
            end
        end
    end

    // Card-to-host table: length, seed, status after fill, last word
    localparam logic [79:0] VEC [6] = '{
        {16'd4,  8'h10, 24'h202500, 32'h13121110},
        {16'd5,  8'h20, 24'h202500, 32'h00000024},
        {16'd7,  8'h30, 24'h202500, 32'h00363534},
        {16'd1,  8'hA5, 24'h202500, 32'h000000A5},
        {16'd36, 8'h00, 24'h20A500, 32'h23222120},
        {16'd64, 8'h80, 24'h22A500, 32'hBFBEBDBC}
    };

    function automatic logic [31:0] exp_word(input logic [7:0] s, input int len, input int j);
        logic [31:0] w;
        w = '0;
        for (int k = 0; k < 4; k++) begin
            if (4 * j + k < len) w[8*k +: 8] = s + 8'(4 * j + k);
        end
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_len(input logic [15:0] v);
        cfg_len_we = 1'b1; cfg_len_wdata = v;
        @(negedge clk);
        cfg_len_we = 1'b0;
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic poll_status();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic poll_count();
        cnt_rd = 1'b1;
        @(negedge clk);
        cnt_rd = 1'b0;
    endtask

    task automatic push(input logic [31:0] v);
        fifo_wr_en = 1'b1; fifo_wr_data = v;
        @(negedge clk);
        fifo_wr_en = 1'b0;
    endtask

    task automatic pop(output logic [31:0] d);
        fifo_rd_en = 1'b1;
        #1 d = fifo_rd_data;
        @(negedge clk);
        fifo_rd_en = 1'b0;
    endtask

    task automatic clear_card();
        card_clr = 1'b1;
        @(negedge clk);
        card_clr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int len;
        int nw;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clear_card();

        // Reset state
        check("R5 reset status", 32'(status), 32'h0);
        check("R1 reset ctrl", 32'(ctrl_rdata), 32'h0);
        check("R9 reset count", 32'(word_cnt), 32'h0);
        check("R2 reset ready", {31'b0, crd_rx_ready | crd_tx_valid}, 32'h0);

        // Table walk: card-to-host packing
        for (int i = 0; i < 6; i++) begin
            len  = int'(VEC[i][79:64]);
            seed = VEC[i][63:56];
            nw   = (len + 3) / 4;
            clear_card();
            card_on = 1'b1;
            set_len(VEC[i][79:64]);
            set_ctrl(8'h03);
            idle(72);
            check("R6 rx status after fill", 32'(status), 32'(VEC[i][55:32]));
            check("R2 count drained", 32'(byte_cnt), 32'h0);
            for (int j = 0; j < nw; j++) begin
                pop(d);
                check("R3 packed word", d, exp_word(seed, len, j));
                if (j == nw - 1) check("R3 last word", d, VEC[i][31:0]);
            end
            pop(d);
            check("R10 empty pop", d, 32'h0);
            poll_status();
            idle(2);
            check("R7 enable cleared", 32'(ctrl_rdata), 32'h02);
            check("R5 done only", 32'(status), 32'h500);
            card_on = 1'b0;
        end

        // Host-to-card unpacking
        clear_card();
        set_len(16'd6);
        set_ctrl(8'h0D);
        check("R1 ctrl stored", 32'(ctrl_rdata), 32'h0D);
        check("R1 count loaded", 32'(byte_cnt), 32'd6);
        check("R6 tx status empty", 32'(status), 32'h45000);
        push(32'h44332211);
        push(32'h88776655);
        check("R6 tx status avail", 32'(status), 32'h105000);
        check("R9 word count", 32'(word_cnt), 32'd2);
        crd_tx_ready = 1'b1;
        idle(12);
        crd_tx_ready = 1'b0;
        check("R4 byte total", 32'(tx_n), 32'd6);
        for (int k = 0; k < 6; k++)
            check("R4 byte order", 32'(tx_bytes[k]), 32'(8'h11 * (k + 1)));
        check("R7 enable cleared", 32'(ctrl_rdata), 32'h0C);
        check("R5 done after tx", 32'(status), 32'h500);

        // Push with counter at zero is ignored
        push(32'hDEADBEEF);
        pop(d);
        check("R10 push ignored", d, 32'h0);

        // Full FIFO drops extra push
        set_len(16'd100);
        set_ctrl(8'h01);
        for (int k = 1; k <= 17; k++) push(32'(k));
        check("R6 tx status full", 32'(status), 32'h111000);
        for (int k = 1; k <= 16; k++) begin
            pop(d);
            check("R10 full order", d, 32'(k));
        end
        pop(d);
        check("R10 overflow dropped", d, 32'h0);
        set_ctrl(8'h00);
        check("R1 no load without enable", 32'(byte_cnt), 32'd100);

        // Refill hold after pop
        poll_status();
        seed = 8'h00;
        clear_card();
        card_on = 1'b1;
        set_len(16'd80);
        set_ctrl(8'h03);
        idle(80);
        check("R8 fill stops at full", 32'(byte_cnt), 32'd16);
        check("R6 rx status full", 32'(status), 32'h22A000);
        check("R9 count rounding", 32'(word_cnt), 32'd4);
        pop(d);
        check("R3 first word", d, 32'h03020100);
        idle(10);
        check("R8 held after pop", 32'(byte_cnt), 32'd16);
        poll_status();
        idle(1);
        check("R2 one byte per clock", 32'(byte_cnt), 32'd15);
        idle(10);
        check("R8 resumed after status", 32'(byte_cnt), 32'd12);
        pop(d);
        check("R3 second word", d, 32'h07060504);
        idle(10);
        check("R8 held again", 32'(byte_cnt), 32'd12);
        poll_count();
        idle(10);
        check("R8 resumed after count", 32'(byte_cnt), 32'd8);
        check("R9 word count", 32'(word_cnt), 32'd2);
        card_on = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule